// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor Core

This block is a small 16-bit processor core. Each instruction is one 16-bit word and takes three or four clock states. In **FETCH** the core reads the word at the program counter (PC) into the instruction register and advances the PC by 2. In **DECODE** it latches two operand registers from the register file. In **EXEC** it computes the result, moves the PC, or performs a store. **WRITEBACK** writes the register file when the instruction produces a register result.

The transitions are fixed. FETCH always goes to DECODE, and DECODE always goes to EXEC. From EXEC the core goes to WRITEBACK for add, sub, slt, lw, lui, lli and jal, and back to FETCH for everything else. WRITEBACK always returns to FETCH.

The core drives one word-addressed memory through an address, write data, read data and a write strobe. The memory returns read data within the same cycle. The core also has:
- a 16-entry register file in which register 0 is always zero;
- an interrupt-enable flag that one instruction toggles;
- an exception-PC register that the return-from-interrupt instruction copies into the PC.

External logic loads the exception-PC register through a load port. Opcodes are held in IR[15:12]. The first register field is IR[11:8], the second is IR[7:4], the destination of three-register forms is IR[3:0], and the 8-bit immediate is IR[7:0].

Top module: `mcore16`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the PC, the interrupt-enable flag and the exception-PC register to 0, and puts the core in FETCH. In FETCH, fetch_o is 1 and mem_addr equals the PC.
- R2: The FETCH state loads the instruction from memory at the PC and sets the PC to PC+2. The states then run FETCH, DECODE, EXEC and, for register-writing opcodes, WRITEBACK, before the next FETCH. An add therefore occupies 4 cycles and a store occupies 3 cycles.
- R3: Opcode 0 (add) and opcode 1 (sub) write Reg[IR[11:8]] + Reg[IR[7:4]], or Reg[IR[11:8]] − Reg[IR[7:4]], to Reg[IR[3:0]], modulo 2^16.
- R4: Opcode 2 (slt) writes bit 15 of Reg[IR[11:8]] − Reg[IR[7:4]] (modulo 2^16), shifted down to bit 0, to Reg[IR[3:0]]. All other result bits are zero.
- R5: Opcode 3 (sw) writes Reg[IR[11:8]] to the memory address held in Reg[IR[7:4]]. mem_we is high for exactly the one EXEC cycle of that instruction.
- R6: Opcode 4 (lw) loads Reg[IR[7:4]] with the memory word at the address held in Reg[IR[11:8]].
- R7: Opcode 7 (lui) sets Reg[IR[11:8]] to {IR[7:0], 8'h00}. Opcode 8 (lli) replaces only the low byte of Reg[IR[11:8]] with IR[7:0] and keeps its upper byte.
- R8: Opcode 5 (bez) sets the PC to (incremented PC) + zero-extended IR[7:0] when Reg[IR[11:8]] is 0. Otherwise the PC keeps its incremented value.
- R9: Opcode 11 (j) sets the PC to (incremented PC) + (sign-extended IR[7:0] shifted left by 1). Opcode 10 (jal) does the same jump and also writes the incremented PC into register 1.
- R10: Opcode 9 (jr) sets the PC to Reg[IR[11:8]].
- R11: Opcode 12 (maski) inverts the interrupt-enable flag. Opcode 13 (rfi) copies the exception-PC register into the PC. epc_we loads epc_din into that register.
- R12: Register 0 reads as zero, and writes to it have no effect.
- R13: Opcodes 6, 14 and 15 change no register, no memory location and no flag. The core proceeds to the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as mem_addr |
| mem_we | output | 1 | Memory write strobe |
| epc_we | input | 1 | Load strobe for the exception-PC register |
| epc_din | input | 16 | Value loaded into the exception-PC register |
| fetch_o | output | 1 | High while the core is in FETCH |
| pc_o | output | 16 | Current PC |
| irq_en_o | output | 1 | Interrupt-enable flag |

## Verification
Register contents are visible only through memory, so every check that touches a register stores it to a known address with sw and then inspects the bench memory. The hardest cases to reach are control-flow paths that must be skipped. For these the bench places stores of a marker value in the region a taken branch or jump should pass over, and confirms that the marker never reaches memory while a store at the landing address does. The jump back to the exception PC depends on a one-cycle load through epc_we that the bench issues just after reset, before the rfi instruction reaches EXEC.

// File: rtl/mcore16_pkg.sv
package mcore16_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_SLT   = 4'd2,
        OP_SW    = 4'd3,
        OP_LW    = 4'd4,
        OP_BEZ   = 4'd5,
        OP_RSV6  = 4'd6,
        OP_LUI   = 4'd7,
        OP_LLI   = 4'd8,
        OP_JR    = 4'd9,
        OP_JAL   = 4'd10,
        OP_J     = 4'd11,
        OP_MASKI = 4'd12,
        OP_RFI   = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WB
    } state_e;

    typedef enum logic [2:0] {
        PC_HOLD,
        PC_INC,
        PC_BRANCH,
        PC_REL,
        PC_REG,
        PC_EPC
    } pc_sel_e;

    typedef enum logic [1:0] {
        AD_PC,
        AD_A,
        AD_B
    } addr_sel_e;

    typedef enum logic [2:0] {
        C_ALU,
        C_MEM,
        C_LUI,
        C_LLI,
        C_LINK
    } c_sel_e;

    typedef enum logic [1:0] {
        D_RD,
        D_RB,
        D_RA,
        D_LINK
    } dst_sel_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic      ir_we;
        logic      ab_we;
        pc_sel_e   pc_sel;
        addr_sel_e addr_sel;
        logic      mem_we;
        logic      c_we;
        c_sel_e    c_sel;
        alu_op_e   alu_op;
        logic      rf_we;
        dst_sel_e  dst_sel;
        logic      ie_flip;
    } ctrl_t;

    localparam ctrl_t CTL_IDLE = '{
        ir_we:    1'b0,
        ab_we:    1'b0,
        pc_sel:   PC_HOLD,
        addr_sel: AD_PC,
        mem_we:   1'b0,
        c_we:     1'b0,
        c_sel:    C_ALU,
        alu_op:   ALU_ADD,
        rf_we:    1'b0,
        dst_sel:  D_RD,
        ie_flip:  1'b0
    };

endpackage

// File: rtl/mcore16_alu.sv
module mcore16_alu
    import mcore16_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  alu_op_e       op,
    output logic [DW-1:0] res
);
    localparam int SIGN_POS = DW - 1;

    logic [DW-1:0] sum;
    logic [DW-1:0] diff;

    assign sum  = opa + opb;
    assign diff = opa - opb;

    always_comb begin
        unique case (op)
            ALU_ADD: res = sum;
            ALU_SUB: res = diff;
            ALU_SLT: res = diff >> SIGN_POS;
            default: res = sum;
        endcase
    end
endmodule

// File: rtl/mcore16_regfile.sv
module mcore16_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (wr_en && wr_addr == AW'(g)) begin
                    regs[g] <= wr_data;
                end
            end
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];
endmodule

// File: rtl/mcore16_ctrl.sv
module mcore16_ctrl
    import mcore16_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e opcode,
    input  logic    a_zero,
    output state_e  state,
    output ctrl_t   ctl
);
    state_e state_q;
    state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // outputs and next state
    always_comb begin
        ctl     = CTL_IDLE;
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                ctl.ir_we  = 1'b1;
                ctl.pc_sel = PC_INC;
                state_d    = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.ab_we = 1'b1;
                state_d   = ST_EXEC;
            end
            ST_EXEC: begin
                state_d = ST_FETCH;
                case (opcode)
                    OP_ADD: begin
                        ctl.c_we   = 1'b1;
                        ctl.alu_op = ALU_ADD;
                        state_d    = ST_WB;
                    end
                    OP_SUB: begin
                        ctl.c_we   = 1'b1;
                        ctl.alu_op = ALU_SUB;
                        state_d    = ST_WB;
                    end
                    OP_SLT: begin
                        ctl.c_we   = 1'b1;
                        ctl.alu_op = ALU_SLT;
                        state_d    = ST_WB;
                    end
                    OP_SW: begin
                        ctl.addr_sel = AD_B;
                        ctl.mem_we   = 1'b1;
                    end
                    OP_LW: begin
                        ctl.addr_sel = AD_A;
                        ctl.c_we     = 1'b1;
                        ctl.c_sel    = C_MEM;
                        state_d      = ST_WB;
                    end
                    OP_BEZ: begin
                        ctl.pc_sel = a_zero ? PC_BRANCH : PC_HOLD;
                    end
                    OP_LUI: begin
                        ctl.c_we  = 1'b1;
                        ctl.c_sel = C_LUI;
                        state_d   = ST_WB;
                    end
                    OP_LLI: begin
                        ctl.c_we  = 1'b1;
                        ctl.c_sel = C_LLI;
                        state_d   = ST_WB;
                    end
                    OP_JR: begin
                        ctl.pc_sel = PC_REG;
                    end
                    OP_JAL: begin
                        ctl.c_we   = 1'b1;
                        ctl.c_sel  = C_LINK;
                        ctl.pc_sel = PC_REL;
                        state_d    = ST_WB;
                    end
                    OP_J: begin
                        ctl.pc_sel = PC_REL;
                    end
                    OP_MASKI: begin
                        ctl.ie_flip = 1'b1;
                    end
                    OP_RFI: begin
                        ctl.pc_sel = PC_EPC;
                    end
                    default: begin
                        state_d = ST_FETCH;
                    end
                endcase
            end
            ST_WB: begin
                ctl.rf_we = 1'b1;
                state_d   = ST_FETCH;
                case (opcode)
                    OP_LW:           ctl.dst_sel = D_RB;
                    OP_LUI, OP_LLI:  ctl.dst_sel = D_RA;
                    OP_JAL:          ctl.dst_sel = D_LINK;
                    default:         ctl.dst_sel = D_RD;
                endcase
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    AST_DECODE_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DECODE |=> state_q == ST_EXEC); // R2
    AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WB |=> state_q == ST_FETCH); // R2
    AST_STORE_THREE_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && opcode == OP_SW) |=> state_q == ST_FETCH); // R5
    AST_RESERVED_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && (opcode == OP_RSV6 || opcode == OP_RSV14 || opcode == OP_RSV15))
        |=> state_q == ST_FETCH); // R13
endmodule

// File: rtl/mcore16.sv
module mcore16
    import mcore16_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    input  logic          epc_we,
    input  logic [DW-1:0] epc_din,
    output logic          fetch_o,
    output logic [DW-1:0] pc_o,
    output logic          irq_en_o
);
    localparam int            AW       = $clog2(NREG);
    localparam int            IMMW     = 8;
    localparam logic [DW-1:0] PC_STEP  = DW'(2);
    localparam logic [AW-1:0] LINK_REG = AW'(1);

    logic [DW-1:0] pc_q, ir_q, a_q, b_q, c_q, epc_q;
    logic          ie_q;

    state_e        state;
    ctrl_t         ctl;
    opcode_e       opcode;
    logic          a_zero;

    logic [AW-1:0] fld_a, fld_b, fld_d, wr_addr;
    logic [IMMW-1:0] imm;
    logic [DW-1:0] imm_sx, imm_zx, rel_target, bez_target;
    logic [DW-1:0] ra_data, rb_data, alu_res, c_next, pc_next;

    assign opcode = opcode_e'(ir_q[15:12]);
    assign fld_a  = ir_q[11:8];
    assign fld_b  = ir_q[7:4];
    assign fld_d  = ir_q[3:0];
    assign imm    = ir_q[IMMW-1:0];
    assign a_zero = (a_q == '0);

    assign imm_sx     = {{(DW-IMMW){imm[IMMW-1]}}, imm};
    assign imm_zx     = {{(DW-IMMW){1'b0}}, imm};
    assign rel_target = pc_q + {imm_sx[DW-2:0], 1'b0};
    assign bez_target = pc_q + imm_zx;

    mcore16_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .a_zero (a_zero),
        .state  (state),
        .ctl    (ctl)
    );

    mcore16_regfile #(
        .DW   (DW),
        .NREG (NREG)
    ) u_rf (
        .clk     (clk),
        .ra_addr (fld_a),
        .rb_addr (fld_b),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .wr_en   (ctl.rf_we),
        .wr_addr (wr_addr),
        .wr_data (c_q)
    );

    mcore16_alu #(
        .DW (DW)
    ) u_alu (
        .opa (a_q),
        .opb (b_q),
        .op  (ctl.alu_op),
        .res (alu_res)
    );

    always_comb begin
        unique case (ctl.addr_sel)
            AD_A:    mem_addr = a_q;
            AD_B:    mem_addr = b_q;
            default: mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = a_q;
    assign mem_we    = ctl.mem_we;

    always_comb begin
        unique case (ctl.dst_sel)
            D_RB:    wr_addr = fld_b;
            D_RA:    wr_addr = fld_a;
            D_LINK:  wr_addr = LINK_REG;
            default: wr_addr = fld_d;
        endcase
    end

    always_comb begin
        unique case (ctl.c_sel)
            C_MEM:   c_next = mem_rdata;
            C_LUI:   c_next = {imm, {(DW-IMMW){1'b0}}};
            C_LLI:   c_next = {a_q[DW-1:IMMW], imm};
            C_LINK:  c_next = pc_q;
            default: c_next = alu_res;
        endcase
    end

    always_comb begin
        unique case (ctl.pc_sel)
            PC_INC:    pc_next = pc_q + PC_STEP;
            PC_BRANCH: pc_next = bez_target;
            PC_REL:    pc_next = rel_target;
            PC_REG:    pc_next = a_q;
            PC_EPC:    pc_next = epc_q;
            default:   pc_next = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            epc_q <= '0;
            ie_q  <= 1'b0;
        end else begin
            pc_q <= pc_next;
            if (ctl.ir_we)   ir_q <= mem_rdata;
            if (ctl.ab_we) begin
                a_q <= ra_data;
                b_q <= rb_data;
            end
            if (ctl.c_we)    c_q  <= c_next;
            if (epc_we)      epc_q <= epc_din;
            if (ctl.ie_flip) ie_q <= ~ie_q;
        end
    end

    assign fetch_o  = (state == ST_FETCH);
    assign pc_o     = pc_q;
    assign irq_en_o = ie_q;

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> pc_q == $past(pc_q) + PC_STEP); // R2
    AST_STORE_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == b_q && mem_wdata == a_q)); // R5
    AST_BEZ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && opcode == OP_BEZ && !a_zero) |=> pc_q == $past(pc_q)); // R8
    AST_JR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && opcode == OP_JR) |=> pc_q == $past(a_q)); // R10
    AST_MASKI_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && opcode == OP_MASKI) |=> ie_q != $past(ie_q)); // R11
    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && fld_a == '0) |=> a_q == '0); // R12
endmodule

// File: tb/mcore16_test.sv
module mcore16_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_o, epc_din;
    logic        mem_we, epc_we, fetch_o, irq_en_o;

    int total = 0;
    int fails = 0;
    int wp = 0;

    logic [15:0] mem [0:1023];

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

    mcore16 uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .epc_we(epc_we), .epc_din(epc_din),
        .fetch_o(fetch_o), .pc_o(pc_o), .irq_en_o(irq_en_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rr(input int op, input int ra, input int rb, input int rd);
        return {op[3:0], ra[3:0], rb[3:0], rd[3:0]};
    endfunction
    function automatic logic [15:0] ri(input int op, input int ra, input int im);
        return {op[3:0], ra[3:0], im[7:0]};
    endfunction

    task automatic put(input logic [15:0] w);
        mem[wp] = w;
        wp += 2;
    endtask
    task automatic ldc(input int r, input logic [15:0] v);
        put(ri(7, r, int'(v[15:8])));
        put(ri(8, r, int'(v[7:0])));
    endtask
    task automatic stv(input int r, input logic [15:0] addr);
        ldc(15, addr);
        put(rr(3, r, 15, 0));
    endtask
    task automatic halt();
        put(16'hB0FF);
    endtask
    task automatic clear();
        rst_n = 1'b0;
        epc_we = 1'b0;
        epc_din = '0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        for (int i = 16'h200; i < 16'h210; i++) mem[i] = 16'hFFFF;
        wp = 0;
    endtask
    task automatic start();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask
    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                                        16'h8000, 16'hFFFF, 16'h1234, 16'h8001};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        int h;

        // R1 reset state
        clear();
        put(16'h0000);
        halt();
        @(negedge clk);
        chk("R1 pc after reset", pc_o, 16'h0000);
        chk("R1 irq_en after reset", {15'b0, irq_en_o}, 16'h0000);
        chk("R1 fetch_o in reset", {15'b0, fetch_o}, 16'h0001);
        chk("R1 mem_addr in reset", mem_addr, 16'h0000);
        chk("R1 mem_we in reset", {15'b0, mem_we}, 16'h0000);

        // R2 state timing: add (4 cycles) then sw (3 cycles)
        clear();
        put(rr(0, 0, 0, 0));
        put(rr(3, 0, 0, 0));
        halt();
        start();
        chk("R2 fetch at release", {15'b0, fetch_o}, 16'h0001);
        run(1);
        chk("R2 pc incremented", pc_o, 16'h0002);
        chk("R2 left fetch", {15'b0, fetch_o}, 16'h0000);
        run(3);
        chk("R2 add takes 4 cycles", {15'b0, fetch_o}, 16'h0001);
        chk("R2 second fetch addr", mem_addr, 16'h0002);
        run(2);
        chk("R5 store strobe in exec", {15'b0, mem_we}, 16'h0001);
        run(1);
        chk("R2 sw takes 3 cycles", {15'b0, fetch_o}, 16'h0001);
        chk("R5 strobe single cycle", {15'b0, mem_we}, 16'h0000);
        chk("R2 third fetch addr", mem_addr, 16'h0004);

        // R3 R4 R5 sweep of operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                clear();
                ldc(2, VALS[i]);
                ldc(3, VALS[j]);
                put(rr(0, 2, 3, 4));
                put(rr(1, 2, 3, 5));
                put(rr(2, 2, 3, 6));
                stv(4, 16'h0200);
                stv(5, 16'h0201);
                stv(6, 16'h0202);
                halt();
                start();
                run(150);
                d = VALS[i] - VALS[j];
                chk("R3 add", mem[16'h200], VALS[i] + VALS[j]);
                chk("R3 sub", mem[16'h201], d);
                chk("R4 slt", mem[16'h202], {15'b0, d[15]});
            end
        end

        // R7 lui clears low byte, lli keeps upper byte
        clear();
        put(ri(7, 2, 8'hAB));
        stv(2, 16'h0200);
        put(ri(8, 2, 8'hCD));
        stv(2, 16'h0201);
        put(ri(7, 2, 8'h12));
        stv(2, 16'h0202);
        halt();
        start();
        run(150);
        chk("R7 lui", mem[16'h200], 16'hAB00);
        chk("R7 lli merge", mem[16'h201], 16'hABCD);
        chk("R7 lui clears low", mem[16'h202], 16'h1200);

        // R6 load word
        clear();
        mem[16'h210] = 16'hBEEF;
        mem[16'h211] = 16'h8001;
        ldc(2, 16'h0210);
        put(rr(4, 2, 9, 0));
        stv(9, 16'h0200);
        ldc(2, 16'h0211);
        put(rr(4, 2, 10, 0));
        stv(10, 16'h0201);
        halt();
        start();
        run(150);
        chk("R6 lw first", mem[16'h200], 16'hBEEF);
        chk("R6 lw second", mem[16'h201], 16'h8001);

        // R12 register 0 ignores writes
        clear();
        mem[16'h210] = 16'h5A5A;
        put(ri(8, 0, 8'h55));
        ldc(2, 16'h0007);
        put(rr(0, 2, 2, 0));
        stv(0, 16'h0200);
        ldc(2, 16'h0210);
        put(rr(4, 2, 0, 0));
        stv(0, 16'h0201);
        halt();
        start();
        run(150);
        chk("R12 r0 after lli/add", mem[16'h200], 16'h0000);
        chk("R12 r0 after lw", mem[16'h201], 16'h0000);

        // R8 bez taken and not taken
        for (int t = 0; t < 2; t++) begin
            clear();
            ldc(4, 16'h00AA);
            ldc(15, 16'h0200);
            put(ri(5, (t == 0) ? 0 : 4, 8));
            for (int k = 0; k < 4; k++) put(rr(3, 4, 15, 0));
            ldc(6, 16'h00BB);
            ldc(15, 16'h0201);
            put(rr(3, 6, 15, 0));
            halt();
            start();
            run(150);
            chk(t == 0 ? "R8 bez taken skips" : "R8 bez not taken", mem[16'h200],
                t == 0 ? 16'hFFFF : 16'h00AA);
            chk("R8 bez continues", mem[16'h201], 16'h00BB);
        end

        // R9 j forward and backward (halt self-loop)
        clear();
        ldc(4, 16'h00AA);
        ldc(15, 16'h0200);
        put(ri(11, 0, 3));
        for (int k = 0; k < 3; k++) put(rr(3, 4, 15, 0));
        ldc(6, 16'h00BB);
        ldc(15, 16'h0201);
        put(rr(3, 6, 15, 0));
        h = wp;
        halt();
        start();
        run(150);
        chk("R9 j skips", mem[16'h200], 16'hFFFF);
        chk("R9 j lands", mem[16'h201], 16'h00BB);
        while (!fetch_o) @(negedge clk);
        chk("R9 j negative offset loops", pc_o, 16'(h));

        // R9 jal link into register 1
        clear();
        ldc(15, 16'h0200);
        put(ri(10, 0, 5));
        for (int k = 0; k < 5; k++) put(rr(3, 0, 15, 0));
        put(rr(3, 1, 15, 0));
        halt();
        start();
        run(150);
        chk("R9 jal link value", mem[16'h200], 16'h0006);

        // R10 jr
        clear();
        ldc(15, 16'h0200);
        ldc(3, 16'h0020);
        put(rr(9, 3, 0, 0));
        put(rr(3, 0, 15, 0));
        halt();
        wp = 16'h20;
        ldc(6, 16'h0077);
        put(rr(3, 6, 15, 0));
        halt();
        start();
        run(150);
        chk("R10 jr target", mem[16'h200], 16'h0077);

        // R11 maski toggling
        for (int n = 1; n <= 3; n++) begin
            clear();
            for (int k = 0; k < n; k++) put(16'hC000);
            halt();
            start();
            run(60);
            chk("R11 maski parity", {15'b0, irq_en_o}, 16'(n % 2));
        end

        // R11 rfi returns to loaded exception PC
        clear();
        put(16'hD000);
        halt();
        wp = 16'h40;
        ldc(6, 16'h0055);
        stv(6, 16'h0200);
        halt();
        start();
        epc_we = 1'b1;
        epc_din = 16'h0040;
        @(negedge clk);
        epc_we = 1'b0;
        run(150);
        chk("R11 rfi to epc", mem[16'h200], 16'h0055);

        // R13 reserved opcodes
        clear();
        ldc(2, 16'h1234);
        put(16'h6222);
        put(16'hE222);
        put(16'hF222);
        stv(2, 16'h0200);
        halt();
        start();
        run(150);
        chk("R13 reserved keep reg", mem[16'h200], 16'h1234);
        chk("R13 reserved no flag", {15'b0, irq_en_o}, 16'h0000);
        chk("R13 reserved no store", mem[16'h201], 16'hFFFF);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule